// File: doc/BRIEF.md
# Indexed Configuration Register Files with Plane Rotation

This block keeps two banks of configuration storage that a host reaches through four byte-wide or word-wide ports: an index and a data port for each bank. The first bank is a flat byte array in which a stored index selects the entry. It acts as an ordinary index/data pair with one exception: entry 0 works as a free-running counter that steps by a fixed amount each time the host reads it.

The second bank holds several planes of word entries. The host sets a row through its index port. A hidden plane pointer then picks which plane each data access touches, and the pointer moves on after every read or write of the data port. The host can therefore stream the words of one row in a fixed order without naming planes. Any write to the row index sends the pointer back to plane 0.

Read results come from a register and appear one clock after the accepted read strobe. A write and a read may be presented in the same cycle. Bus address decoding and the meaning of the stored values are outside this block.

Top module: `cfgIndexRegs`

## Requirements
- R1: After reset, bank A index is 0, bank A entry 0 holds 0x10, every other bank A entry is 0, the bank B row and plane pointer are 0, every bank B entry is 0, and rdValid is low.
- R2: Port codes are 0 = bank A index, 1 = bank A data, 2 = bank B index, 3 = bank B data. A read accepted with rdEn high at a clock edge drives rdValid high and rdData with the zero-extended value on the following cycle. rdValid is low in any cycle that follows no accepted read.
- R3: Writing port 0 stores the index, and a read of port 0 returns it. Writing port 1 stores the low byte of wrData into the entry that the index selects, and a read of port 1 returns that entry.
- R4: A read of port 1 while the index is 0 returns the stored value and then adds 0x40 to entry 0, modulo 256. Reads of any other entry leave it unchanged.
- R5: Writing port 2 sets the bank B row to the low byte of wrData and clears the plane pointer to 0.
- R6: Each read or write of port 3 uses the entry at the current plane and row, then advances the plane pointer by one modulo 4, so the fifth access returns to plane 0.
- R7: A read of port 2 returns the row alone and does not move the plane pointer.
- R8: If a write and a read target the same data port in one cycle, the read returns the value held before the write and the write is stored. On port 1 at index 0 no 0x40 step is applied. On port 3 the plane pointer advances only once.
- R9: While rdEn is low, the value on rdPort has no effect: no step of entry 0 and no plane advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrPort | input | 2 | Port code for the write |
| wrData | input | 16 | Write data (bank A uses the low byte) |
| rdEn | input | 1 | Read strobe |
| rdPort | input | 2 | Port code for the read |
| rdData | output | 16 | Registered read data, zero-extended |
| rdValid | output | 1 | rdData holds the result of the previous cycle's read |

## Verification
A wrong plane pointer shows on the very next port 3 read as a word from a neighbouring plane. After a row index write it shows as a first word that is not the plane-0 word. An error in entry 0 shows at the next read of index 0 as a value that is off by a multiple of 0x40. A stray side effect from an unstrobed read, or a double advance on a combined read and write, is exposed within one read of the affected port. The bench sweeps every bank A entry and every row and plane of bank B against an arithmetic model.

// File: rtl/cfgIdxPkg.sv
package cfgIdxPkg;
  typedef enum logic [1:0] {
    PORT_A_IDX  = 2'd0,
    PORT_A_DATA = 2'd1,
    PORT_B_IDX  = 2'd2,
    PORT_B_DATA = 2'd3
  } portSel_e;

  typedef struct packed {
    logic     aIdxWr;
    logic     aDataWr;
    logic     aBump;
    logic     bIdxWr;
    logic     bDataWr;
    logic     bAdvance;
    logic     rdAny;
    portSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/cfgIdxCtrl.sv
module cfgIdxCtrl
  import cfgIdxPkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrPort,
  input  logic       rdEn,
  input  logic [1:0] rdPort,
  input  logic       aIdxIsZero,
  output strobe_t    st
);
  portSel_e wrSel;
  portSel_e rdSel;
  logic     aDataRd;
  logic     bDataRd;

  always_comb begin
    wrSel   = portSel_e'(wrPort);
    rdSel   = portSel_e'(rdPort);
    aDataRd = rdEn && (rdSel == PORT_A_DATA);
    bDataRd = rdEn && (rdSel == PORT_B_DATA);

    st.aIdxWr   = wrEn && (wrSel == PORT_A_IDX);
    st.aDataWr  = wrEn && (wrSel == PORT_A_DATA);
    st.bIdxWr   = wrEn && (wrSel == PORT_B_IDX);
    st.bDataWr  = wrEn && (wrSel == PORT_B_DATA);
    // the write wins over the counting side effect on entry 0
    st.aBump    = aDataRd && aIdxIsZero && !st.aDataWr;
    // one shared advance for any data access on bank B
    st.bAdvance = st.bDataWr || bDataRd;
    st.rdAny    = rdEn;
    st.rdSel    = rdSel;
  end
endmodule

// File: rtl/cfgIdxData.sv
module cfgIdxData
  import cfgIdxPkg::*;
#(
  parameter int A_IDX_W  = 8,
  parameter int A_DW     = 8,
  parameter int B_ROW_W  = 8,
  parameter int B_DW     = 16,
  parameter int PLANE_W  = 2,
  parameter int BUS_W    = 16,
  parameter logic [A_DW-1:0] A_BUMP = 8'h40,
  parameter logic [A_DW-1:0] A_INIT = 8'h10
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [BUS_W-1:0] wrData,
  output logic             aIdxIsZero,
  output logic [BUS_W-1:0] rdData,
  output logic             rdValid
);
  localparam int A_DEPTH = 1 << A_IDX_W;
  localparam int B_DEPTH = 1 << (B_ROW_W + PLANE_W);

  logic [A_DW-1:0]    aMem [A_DEPTH];
  logic [A_IDX_W-1:0] aIdx;
  logic [B_DW-1:0]    bMem [B_DEPTH];
  logic [B_ROW_W-1:0] bRow;
  logic [PLANE_W-1:0] plane;
  logic [B_ROW_W+PLANE_W-1:0] bAddr;
  logic [BUS_W-1:0]   rdNext;

  assign aIdxIsZero = (aIdx == '0);
  assign bAddr      = {plane, bRow};

  // bank A storage and index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aIdx <= '0;
      for (int i = 0; i < A_DEPTH; i++) aMem[i] <= (i == 0) ? A_INIT : '0;
    end else begin
      if (st.aIdxWr) aIdx <= wrData[A_IDX_W-1:0];
      if (st.aDataWr)    aMem[aIdx] <= wrData[A_DW-1:0];
      else if (st.aBump) aMem[0]    <= aMem[0] + A_BUMP;
    end
  end

  // bank B storage, row and rotating plane pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bRow  <= '0;
      plane <= '0;
      for (int i = 0; i < B_DEPTH; i++) bMem[i] <= '0;
    end else begin
      if (st.bDataWr) bMem[bAddr] <= wrData[B_DW-1:0];
      if (st.bIdxWr) begin
        bRow  <= wrData[B_ROW_W-1:0];
        plane <= '0;
      end else if (st.bAdvance) begin
        plane <= plane + 1'b1;
      end
    end
  end

  // read mux: always the state held before this cycle's writes
  always_comb begin
    unique case (st.rdSel)
      PORT_A_IDX:  rdNext = BUS_W'(aIdx);
      PORT_A_DATA: rdNext = BUS_W'(aMem[aIdx]);
      PORT_B_IDX:  rdNext = BUS_W'(bRow);
      default:     rdNext = BUS_W'(bMem[bAddr]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= st.rdAny;
      if (st.rdAny) rdData <= rdNext;
    end
  end

  // R2
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.rdAny |=> rdValid);
  // R2
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.rdAny |=> !rdValid);
  // R4
  zero_bump_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.aBump |=> aMem[0] == A_DW'($past(aMem[0]) + A_BUMP));
  // R8
  zero_write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.aDataWr && aIdxIsZero) |=> aMem[0] == $past(wrData[A_DW-1:0]));
  // R5
  plane_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.bIdxWr |=> plane == '0);
  // R6
  plane_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.bAdvance && !st.bIdxWr) |=> plane == PLANE_W'($past(plane) + 1'b1));
  // R9
  plane_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.bAdvance && !st.bIdxWr) |=> $stable(plane));
endmodule

// File: rtl/cfgIndexRegs.sv
module cfgIndexRegs
  import cfgIdxPkg::*;
#(
  parameter int A_IDX_W = 8,
  parameter int A_DW    = 8,
  parameter int B_ROW_W = 8,
  parameter int B_DW    = 16,
  parameter int PLANE_W = 2,
  localparam int BUS_W  = (A_DW > B_DW) ? A_DW : B_DW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrPort,
  input  logic [BUS_W-1:0] wrData,
  input  logic             rdEn,
  input  logic [1:0]       rdPort,
  output logic [BUS_W-1:0] rdData,
  output logic             rdValid
);
  strobe_t st;
  logic    aIdxIsZero;

  cfgIdxCtrl u_ctrl (
    .wrEn       (wrEn),
    .wrPort     (wrPort),
    .rdEn       (rdEn),
    .rdPort     (rdPort),
    .aIdxIsZero (aIdxIsZero),
    .st         (st)
  );

  cfgIdxData #(
    .A_IDX_W (A_IDX_W),
    .A_DW    (A_DW),
    .B_ROW_W (B_ROW_W),
    .B_DW    (B_DW),
    .PLANE_W (PLANE_W),
    .BUS_W   (BUS_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .wrData     (wrData),
    .aIdxIsZero (aIdxIsZero),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );
endmodule

// File: tb/cfgIndexRegs_tb.sv
module cfgIndexRegs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrPort = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdPort = '0;
  logic [15:0] rdData;
  logic        rdValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0]  mA [256];
  logic [15:0] mB [1024];
  logic [7:0]  mIdx;
  logic [7:0]  mRow;
  logic [1:0]  mPlane;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgIndexRegs u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrPort(wrPort), .wrData(wrData),
    .rdEn(rdEn), .rdPort(rdPort), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] modelRead(input logic [1:0] p);
    logic [15:0] v;
    case (p)
      2'd0: v = {8'h00, mIdx};
      2'd1: begin
        v = {8'h00, mA[mIdx]};
        if (mIdx == 0) mA[0] = mA[0] + 8'h40;
      end
      2'd2: v = {8'h00, mRow};
      default: begin
        v = mB[{mPlane, mRow}];
        mPlane = mPlane + 2'd1;
      end
    endcase
    return v;
  endfunction

  task automatic modelWrite(input logic [1:0] p, input logic [15:0] d);
    case (p)
      2'd0: mIdx = d[7:0];
      2'd1: mA[mIdx] = d[7:0];
      2'd2: begin mRow = d[7:0]; mPlane = 2'd0; end
      default: begin mB[{mPlane, mRow}] = d; mPlane = mPlane + 2'd1; end
    endcase
  endtask

  task automatic doWrite(input logic [1:0] p, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrPort = p; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(p, d);
  endtask

  task automatic doRead(input logic [1:0] p, input string req);
    logic [15:0] exp;
    @(negedge clk);
    rdEn = 1'b1; rdPort = p;
    @(negedge clk);
    rdEn = 1'b0;
    exp = modelRead(p);
    check(rdValid === 1'b1 && rdData === exp, req, rdData, exp);
  endtask

  // write and read of the same data port in one cycle
  task automatic doBoth(input logic [1:0] p, input logic [15:0] d, input string req);
    logic [15:0] exp;
    @(negedge clk);
    wrEn = 1'b1; wrPort = p; wrData = d; rdEn = 1'b1; rdPort = p;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    if (p == 2'd1) exp = {8'h00, mA[mIdx]};
    else           exp = mB[{mPlane, mRow}];
    modelWrite(p, d);
    check(rdValid === 1'b1 && rdData === exp, req, rdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mA[i] = 8'h00;
    mA[0] = 8'h10;
    for (int i = 0; i < 1024; i++) mB[i] = 16'h0000;
    mIdx = 0; mRow = 0; mPlane = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rdValid === 1'b0, "R1 rdValid", {15'h0, rdValid}, 16'h0);
    doRead(2'd0, "R1 A index");
    doRead(2'd1, "R1 A entry0");
    doRead(2'd2, "R1 B row");
    doRead(2'd3, "R1 B entry");
    @(negedge clk);
    check(rdValid === 1'b0, "R2 idle rdValid", {15'h0, rdValid}, 16'h0);

    // R3 sweep bank A index and data
    for (int i = 0; i < 256; i++) begin
      doWrite(2'd0, 16'(i) | 16'hAB00);
      doRead(2'd0, "R3 index readback");
      doWrite(2'd1, 16'((i * 37 + 5) & 8'hFF) | 16'h7700);
    end
    for (int i = 255; i >= 0; i--) begin
      doWrite(2'd0, 16'(i));
      doRead(2'd1, "R3 entry readback");
      doRead(2'd1, "R4 repeat read");
    end

    // R4 counter wraps modulo 256
    doWrite(2'd0, 16'h0000);
    doWrite(2'd1, 16'h00F0);
    for (int k = 0; k < 5; k++) doRead(2'd1, "R4 step 0x40");

    // R5/R6 sweep bank B rows and planes
    for (int r = 0; r < 256; r++) begin
      doWrite(2'd2, 16'(r));
      for (int p = 0; p < 4; p++) doWrite(2'd3, 16'(r * 257 + p * 4099 + 1));
    end
    for (int r = 0; r < 256; r++) begin
      doWrite(2'd2, 16'hFF00 | 16'(r));
      for (int p = 0; p < 5; p++) doRead(2'd3, "R6 plane rotate");
      doRead(2'd2, "R7 row only");
      doRead(2'd3, "R7 no plane move");
    end
    // R5 index write mid-rotation resets plane
    doWrite(2'd2, 16'd9);
    doRead(2'd3, "R6 first");
    doRead(2'd3, "R6 second");
    doWrite(2'd2, 16'd9);
    doRead(2'd3, "R5 plane cleared");

    // R8 same-cycle read and write
    doWrite(2'd0, 16'h0000);
    doBoth(2'd1, 16'h0055, "R8 A old value");
    doRead(2'd1, "R8 A write kept no bump");
    doRead(2'd1, "R8 A bump after");
    doWrite(2'd2, 16'd3);
    doBoth(2'd3, 16'hBEEF, "R8 B old value");
    doRead(2'd3, "R8 B single advance");
    doWrite(2'd2, 16'd3);
    doRead(2'd3, "R8 B write stored");

    // R9 unstrobed rdPort has no effect
    doWrite(2'd0, 16'h0000);
    doWrite(2'd2, 16'd7);
    @(negedge clk);
    rdPort = 2'd1;
    repeat (4) @(negedge clk);
    rdPort = 2'd3;
    repeat (4) @(negedge clk);
    check(rdValid === 1'b0, "R9 no valid", {15'h0, rdValid}, 16'h0);
    doRead(2'd1, "R9 entry0 unchanged");
    doRead(2'd3, "R9 plane unchanged");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule